// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block merges the system's reset sources into one synchronous, active-low system reset. Four sources feed it. An active-low external pin is synchronized and passed through a low-time filter. A power-on detect acts as the asynchronous master reset. A main-supply brown-out comparator is watched in the normal operating modes. A low-power brown-out comparator is watched only in deep sleep. After a power-on or brown-out condition the reset is held until a power-up timer has counted out. The timer starts again whenever a brown-out condition comes back while it is counting.

Software reads the reset cause through a small register bus. The status register holds two sticky, active-low cause flags, one for power-on and one for brown-out, plus a deep-sleep-wake bit. Two general-purpose holding registers sit beside it. They survive pin resets and main brown-outs but are wiped by a power-on or a low-power brown-out. The external pin is an input only, and nothing in the block drives it.

Top module: `rst_seq_top`

## Requirements
- R1: Once the synchronized external pin has been low for FILT_LEN (default 16) consecutive clocks, sys_rst_n goes low and stays low while the pin stays low. It returns high a few clocks after the pin rises, without waiting for the power-up timer.
- R2: A low pulse on the external pin shorter than FILT_LEN clocks leaves sys_rst_n high.
- R3: While por_n is low, sys_rst_n and every bus register read 0. After por_n rises, sys_rst_n stays low until the power-up timer has counted PUT_LEN (default 1024) clocks.
- R4: Outside deep sleep, with bor_main_en=1, bor_main=1 asserts reset. Any return of the condition while the power-up timer is counting restarts the full PUT_LEN count.
- R5: The power-on flag sits at address 0, bit 0. It is 0 after power-on and is left unchanged by pin resets and main brown-outs. A bus write with that bit at 1 sets it. A write with that bit at 0 has no effect.
- R6: The brown-out flag sits at address 0, bit 1. Power-on and an enabled main brown-out clear it to 0. A bus write with that bit at 1 sets it.
- R7: With bor_main_en=0, or while deep_sleep=1, bor_main neither resets the system nor changes the brown-out flag.
- R8: A low-power brown-out occurs when deep_sleep=1, bor_lp_en=1 and bor_lp=1. It acts like a power-on: it asserts reset with a full timer hold and clears both cause flags and both holding registers (address 1 and address 2). With bor_lp_en=0 it has no effect. The holding registers keep their contents across pin resets and main brown-outs.
- R9: The deep-sleep-wake bit sits at address 0, bit 2. It becomes 1 when deep_sleep falls while sys_rst_n is high. A low-power brown-out clears it, and it stays 0 when deep_sleep falls during the reset that follows.
- R10: When a reset event and a bus write to the same flag or register fall in the same clock, the reset event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on detect, low while supply is not yet valid; asynchronous master reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bor_main | input | 1 | Main-supply brown-out comparator, 1 = below threshold |
| bor_lp | input | 1 | Low-power-mode brown-out comparator, 1 = below threshold |
| bor_main_en | input | 1 | Configuration enable of the main-supply monitor |
| bor_lp_en | input | 1 | Enable of the low-power monitor |
| deep_sleep | input | 1 | Mode flag, 1 = deep sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 status, 1 and 2 holding registers |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| sys_rst_n | output | 1 | Synchronous system reset, active low |

## Verification
A software write that sets a cause flag, or that loads a holding register, can land in the same clock as a reset event that clears it. The bench provokes this by holding the low-power comparator high in deep sleep and issuing a status write of both flag bits, and a holding-register write, while the event is active. The result counts as correct only if the flags and registers read 0 afterwards. In a second coincidence, a brown-out returns partway through the power-up count, and the bench confirms that reset is still low at a time when a timer that had not restarted would already have released it.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam logic [1:0] ADDR_STAT  = 2'd0;
  localparam logic [1:0] ADDR_HOLD0 = 2'd1;
  localparam logic [1:0] ADDR_HOLD1 = 2'd2;
  localparam int STAT_POR = 0;
  localparam int STAT_BOR = 1;
  localparam int STAT_DSW = 2;
endpackage

// File: rtl/rst_sync_2ff.sv
module rst_sync_2ff #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic act
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pin_s)
      cnt_d = '0;
    else if (cnt_q != LIM)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act = (cnt_q == LIM);

  // R2: acceptance only follows a low pin
  p_glitch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(!pin_s));
endmodule

// File: rtl/rst_put_timer.sv
module rst_put_timer #(
  parameter int PUT_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(PUT_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(PUT_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (cnt_q != LIM)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);

  // R4: a returning condition always removes the expired state
  p_put_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done);
endmodule

// File: rtl/rst_status_regs.sv
module rst_status_regs
  import rst_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_bor,
  input  logic          lp_bor,
  input  logic          deep_sleep,
  input  logic          sys_up,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic por_q, por_d, bor_q, bor_d, dsw_q, dsw_d, dsp_q;
  logic [DW-1:0] hold0_q, hold0_d, hold1_q, hold1_d;
  logic wr_stat;

  assign wr_stat = wr && (addr == ADDR_STAT);

  always_comb begin
    por_d = por_q;
    if (lp_bor)
      por_d = 1'b0;
    else if (wr_stat && wdata[STAT_POR])
      por_d = 1'b1;

    bor_d = bor_q;
    if (lp_bor || main_bor)
      bor_d = 1'b0;
    else if (wr_stat && wdata[STAT_BOR])
      bor_d = 1'b1;

    dsw_d = dsw_q;
    if (lp_bor)
      dsw_d = 1'b0;
    else if (dsp_q && !deep_sleep && sys_up)
      dsw_d = 1'b1;

    hold0_d = hold0_q;
    hold1_d = hold1_q;
    if (lp_bor) begin
      hold0_d = '0;
      hold1_d = '0;
    end else if (wr) begin
      if (addr == ADDR_HOLD0) hold0_d = wdata;
      if (addr == ADDR_HOLD1) hold1_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q   <= 1'b0;
      bor_q   <= 1'b0;
      dsw_q   <= 1'b0;
      dsp_q   <= 1'b0;
      hold0_q <= '0;
      hold1_q <= '0;
    end else begin
      por_q   <= por_d;
      bor_q   <= bor_d;
      dsw_q   <= dsw_d;
      dsp_q   <= deep_sleep;
      hold0_q <= hold0_d;
      hold1_q <= hold1_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_STAT: begin
        rdata[STAT_POR] = por_q;
        rdata[STAT_BOR] = bor_q;
        rdata[STAT_DSW] = dsw_q;
      end
      ADDR_HOLD0: rdata = hold0_q;
      ADDR_HOLD1: rdata = hold1_q;
      default: rdata = '0;
    endcase
  end

  // R5: once set, the power-on flag is only lost to a power-like event
  p_por_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !lp_bor) |=> por_q);
  // R6: brown-out clears its flag
  p_bor_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_bor || lp_bor) |=> !bor_q);
  // R8: low-power brown-out wipes the holding registers
  p_hold_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_bor |=> (hold0_q == '0 && hold1_q == '0));
  // R9: wake bit is 0 after a low-power brown-out
  p_dsw_lp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_bor |=> !dsw_q);
  // R10: event beats a simultaneous set request
  p_evt_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_bor && wr_stat && wdata[STAT_POR]) |=> !por_q);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int FILT_LEN = 16,
  parameter int PUT_LEN  = 1024,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ext_rst_n,
  input  logic          bor_main,
  input  logic          bor_lp,
  input  logic          bor_main_en,
  input  logic          bor_lp_en,
  input  logic          deep_sleep,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sys_rst_n
);
  logic rst_n_i;
  logic pin_s, bm_s, bl_s;
  logic main_evt, lp_evt, pwr_evt;
  logic ext_act, put_done;
  logic sys_q, sys_d;

  rst_sync_2ff #(.W(1), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(rst_n_i)
  );

  rst_sync_2ff #(.W(3), .RST_VAL(3'b100)) u_in_sync (
    .clk(clk), .rst_n(rst_n_i),
    .d({ext_rst_n, bor_main, bor_lp}),
    .q({pin_s, bm_s, bl_s})
  );

  assign main_evt = !deep_sleep && bor_main_en && bm_s;
  assign lp_evt   = deep_sleep && bor_lp_en && bl_s;
  assign pwr_evt  = main_evt || lp_evt;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n_i), .pin_s(pin_s), .act(ext_act)
  );

  rst_put_timer #(.PUT_LEN(PUT_LEN)) u_put (
    .clk(clk), .rst_n(rst_n_i), .restart(pwr_evt), .done(put_done)
  );

  rst_status_regs #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n_i),
    .main_bor(main_evt), .lp_bor(lp_evt),
    .deep_sleep(deep_sleep), .sys_up(sys_q),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata)
  );

  always_comb begin
    sys_d = put_done && !pwr_evt && !ext_act;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sys_q <= 1'b0;
    else          sys_q <= sys_d;
  end

  assign sys_rst_n = sys_q;

  // R1: accepted pin reset drives the system reset
  p_pin_rst_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    ext_act |=> !sys_rst_n);
  // R4: a power condition holds the system in reset
  p_pwr_rst_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    pwr_evt |=> !sys_rst_n);
  // R3: release never happens before the timer has expired
  p_put_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(sys_rst_n) |-> $past(put_done));
endmodule

// File: tb/rst_seq_top_test.sv
`timescale 1ns/1ps
module rst_seq_top_test;
  localparam int FILT = 16;
  localparam int PUT  = 1024;

  logic clk = 1'b0;
  logic por_n, ext_rst_n, bor_main, bor_lp, bor_main_en, bor_lp_en, deep_sleep;
  logic bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic sys_rst_n;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R3";

  always #4 clk = ~clk;

  rst_seq_top uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bor_main(bor_main),
    .bor_lp(bor_lp), .bor_main_en(bor_main_en), .bor_lp_en(bor_lp_en),
    .deep_sleep(deep_sleep), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_n(sys_rst_n)
  );

  // behavioural reference
  int m_ps1, m_ps2, m_fc, m_pc;
  bit m_sys, m_por, m_bor, m_dsw, m_dsp;
  logic [7:0] m_h0, m_h1;
  bit q_pin[$], q_bm[$], q_bl[$];
  bit o_rst, pin_s, bm_s, bl_s, me, le, pe, n_sys;

  task automatic m_reset();
    m_ps1 = 0; m_ps2 = 0; m_fc = 0; m_pc = 0;
    m_sys = 0; m_por = 0; m_bor = 0; m_dsw = 0; m_dsp = 0;
    m_h0 = 8'h00; m_h1 = 8'h00;
    q_pin = '{1, 1}; q_bm = '{0, 0}; q_bl = '{0, 0};
  endtask

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: m_rd = {5'b0, m_dsw, m_bor, m_por};
      2'd1: m_rd = m_h0;
      2'd2: m_rd = m_h1;
      default: m_rd = 8'h00;
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!por_n) m_reset();
    else begin
      o_rst = (m_ps2 != 0);
      m_ps2 = m_ps1; m_ps1 = 1;
      if (o_rst) begin
        pin_s = q_pin[0]; bm_s = q_bm[0]; bl_s = q_bl[0];
        me = !deep_sleep && bor_main_en && bm_s;
        le = deep_sleep && bor_lp_en && bl_s;
        pe = me || le;
        n_sys = (m_pc == PUT) && !pe && (m_fc != FILT);
        m_fc = pin_s ? 0 : ((m_fc < FILT) ? m_fc + 1 : m_fc);
        m_pc = pe ? 0 : ((m_pc < PUT) ? m_pc + 1 : m_pc);
        if (le) m_por = 0;
        else if (bus_wr && bus_addr == 2'd0 && bus_wdata[0]) m_por = 1;
        if (pe) m_bor = 0;
        else if (bus_wr && bus_addr == 2'd0 && bus_wdata[1]) m_bor = 1;
        if (le) m_dsw = 0;
        else if (m_dsp && !deep_sleep && m_sys) m_dsw = 1;
        m_dsp = deep_sleep;
        if (le) begin m_h0 = 8'h00; m_h1 = 8'h00; end
        else if (bus_wr) begin
          if (bus_addr == 2'd1) m_h0 = bus_wdata;
          if (bus_addr == 2'd2) m_h1 = bus_wdata;
        end
        m_sys = n_sys;
        void'(q_pin.pop_front()); q_pin.push_back(ext_rst_n);
        void'(q_bm.pop_front());  q_bm.push_back(bor_main);
        void'(q_bl.pop_front());  q_bl.push_back(bor_lp);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!por_n) m_reset();
    n_chk++;
    if (sys_rst_n !== m_sys || bus_rdata !== m_rd(bus_addr)) begin
      n_fail++;
      $display("FAIL %s cycle compare: sys_rst_n=%b rdata=%h expected sys_rst_n=%b rdata=%h",
               cur_req, sys_rst_n, bus_rdata, m_sys, m_rd(bus_addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = 2'd0; bus_wdata = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_addr = 2'd0;
  endtask

  task automatic rst_chk(input string req, input logic exp);
    @(negedge clk);
    #2 chk(req, {7'b0, sys_rst_n}, {7'b0, exp});
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    por_n = 0; ext_rst_n = 1; bor_main = 0; bor_lp = 0;
    bor_main_en = 1; bor_lp_en = 0; deep_sleep = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    // R3: reset state and power-up hold
    cur_req = "R3";
    step(5);
    rst_chk("R3 reset state", 1'b0);
    rd_chk("R3 status in reset", 2'd0, 8'h00);
    por_n = 1;
    step(1000);
    rst_chk("R3 held by timer", 1'b0);
    step(40);
    rst_chk("R3 released", 1'b1);

    // R5 R6: software set, write 0 ignored
    cur_req = "R5 R6";
    rd_chk("R5 flags after power-on", 2'd0, 8'h00);
    wr(2'd0, 8'h01);
    rd_chk("R5 set por flag", 2'd0, 8'h01);
    wr(2'd0, 8'h00);
    rd_chk("R5 write 0 no effect", 2'd0, 8'h01);
    wr(2'd0, 8'h02);
    rd_chk("R6 set bor flag", 2'd0, 8'h03);
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h3C);

    // R2: short glitch
    cur_req = "R2";
    @(negedge clk) ext_rst_n = 0;
    step(FILT - 6);
    ext_rst_n = 1;
    step(10);
    rst_chk("R2 glitch rejected", 1'b1);

    // R1: long low
    cur_req = "R1";
    ext_rst_n = 0;
    step(FILT + 10);
    rst_chk("R1 pin reset asserted", 1'b0);
    ext_rst_n = 1;
    step(8);
    rst_chk("R1 pin reset released", 1'b1);
    rd_chk("R5 flags kept over pin reset", 2'd0, 8'h03);
    rd_chk("R8 hold0 kept over pin reset", 2'd1, 8'hA5);

    // R4 R6: main brown-out with timer restart
    cur_req = "R4 R6";
    bor_main = 1; step(5);
    rst_chk("R4 brown-out asserts reset", 1'b0);
    bor_main = 0; step(200);
    bor_main = 1; step(5);
    bor_main = 0; step(1000);
    rst_chk("R4 timer restarted", 1'b0);
    step(40);
    rst_chk("R4 released after timer", 1'b1);
    rd_chk("R6 bor cleared, R5 por kept", 2'd0, 8'h01);
    rd_chk("R8 hold1 kept over brown-out", 2'd2, 8'h3C);
    wr(2'd0, 8'h02);

    // R7: disabled or deep-sleep main monitor
    cur_req = "R7";
    bor_main_en = 0; bor_main = 1; step(20);
    rst_chk("R7 disabled monitor no reset", 1'b1);
    rd_chk("R7 bor kept when disabled", 2'd0, 8'h03);
    bor_main = 0; step(3);
    bor_main_en = 1; deep_sleep = 1; bor_main = 1; step(20);
    rst_chk("R7 ignored in deep sleep", 1'b1);
    bor_main = 0; step(3);

    // R8: low-power monitor disabled
    cur_req = "R8 R9";
    bor_lp = 1; step(20);
    rst_chk("R8 lp monitor disabled", 1'b1);
    rd_chk("R8 flags unchanged when disabled", 2'd0, 8'h03);
    bor_lp = 0; step(3);
    // R9: normal wake
    deep_sleep = 0; step(4);
    rd_chk("R9 wake bit set", 2'd0, 8'h07);

    // R10 R8 R9: low-power brown-out with simultaneous writes
    cur_req = "R10 R8 R9";
    deep_sleep = 1; bor_lp_en = 1; step(2);
    bor_lp = 1; step(5);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hFF);
    step(3);
    bor_lp = 0; step(100);
    deep_sleep = 0; step(10);
    rst_chk("R8 lp brown-out holds reset", 1'b0);
    rd_chk("R10 event beats write, R9 wake 0", 2'd0, 8'h00);
    rd_chk("R8 hold0 wiped", 2'd1, 8'h00);
    rd_chk("R8 hold1 wiped", 2'd2, 8'h00);
    step(PUT);
    rst_chk("R8 released after timer", 1'b1);
    rd_chk("R9 wake bit stays 0", 2'd0, 8'h00);

    step(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule